// File: doc/BRIEF.md
# Radix-2 Delay-Feedback Butterfly Stage

This block is one stage of a pipelined radix-2 FFT that takes one complex sample per valid clock. It keeps half a frame of samples in a feedback shift register of depth D. Each frame is 2D valid samples long. In the first half of a frame (the fill phase) the stage stores the incoming samples and sends out what the delay line returns. That is the set of differences left by the previous frame. In the second half (the butterfly phase) it pairs each incoming sample b with the sample a that entered D valid cycles earlier. It sends a+b out and writes the difference back into the delay line.

The difference is formed as a + ~b, which equals a − b − 1. The two's-complement +1 is left out on purpose, so each difference carries a bias of one LSB. Output words are one bit wider than input words, so neither the sum nor the biased difference can overflow. Twiddle multiplication and output reordering belong to the blocks that follow.

Top module: `sdf_bfly_stage`

## Requirements
- R1: While reset is low at a clock edge, out_valid, out_re and out_im are all zero. The first valid sample after reset is sample 0 of a new frame.
- R2: out_valid is high in the cycle after a valid input only when at least D valid samples were accepted before that input since reset. The first D valid inputs produce no valid output.
- R3: A cycle with in_valid low changes no state. out_valid is low in the next cycle, out_re and out_im keep their values, and frame position, stored samples and pairing are unaffected.
- R4: For valid sample n with position p = n mod 2D and p ≥ D (butterfly phase), the output is x[n−D] + x[n], computed separately for the real and imaginary parts.
- R5: For valid sample n with p < D and n ≥ 2D (fill phase), the output is x[n−2D] − x[n−D] − 1, the biased difference of the pair from the previous frame.
- R6: Outputs are signed and IN_W+1 bits wide. Sums and differences of full-scale inputs (both maximum, both minimum, and mixed signs) come out exact, with no wrap.
- R7: Frames are exactly 2D valid samples long. The phase of sample n is taken from bit log2(D) of n mod 2D: 0 means fill, 1 means butterfly.
- R8: The result for an accepted input is visible on out_re and out_im one clock edge after that input is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | IN_W | Real part of the input, signed |
| in_im | input | IN_W | Imaginary part of the input, signed |
| out_valid | output | 1 | Output sample present this cycle |
| out_re | output | IN_W+1 | Real part of the result, signed |
| out_im | output | IN_W+1 | Imaginary part of the result, signed |

## Verification
A ramp with no gaps shows whether samples are paired with the right partner D positions back, and whether frame boundaries fall every 2D samples. Random data with random gaps in in_valid separates a counter that advances per clock from one that advances per accepted sample, and it also exposes a delay line that shifts on idle cycles. Full-scale patterns (both operands at maximum, both at minimum, opposite signs) show whether the extra output bit and the sign extension are right. A second reset in mid-frame checks that the frame position and the priming count restart.

// File: rtl/sdf_pkg.sv
// Shared types for the delay-feedback butterfly stage.
// Assumes nothing beyond a single clock domain.
package sdf_pkg;

    // Phase of the stage within one 2D-sample frame
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_BFLY = 1'b1
    } phase_e;

endpackage

// File: rtl/sdf_ctrl.sv
// Frame controller: counts accepted samples modulo 2*DEPTH.
// The top bit of the count is the phase. A sticky flag marks
// that DEPTH samples have entered, so the delay line holds real data.
// Assumes DEPTH is a power of two.
module sdf_ctrl
    import sdf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output phase_e phase,
    output logic   primed
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0] cnt;

    // Advance the frame position on every accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (in_valid) cnt <= cnt + CNT_W'(1);
    end

    // Set once the DEPTH-th sample has been accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                                        primed <= 1'b0;
        else if (in_valid && cnt == CNT_W'(DEPTH - 1))     primed <= 1'b1;
    end

    assign phase = phase_e'(cnt[CNT_W-1]);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

    // R2
    primed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed);

endmodule

// File: rtl/sdf_delay.sv
// Feedback delay line built as a plain shift register of DEPTH words.
// It shifts only when shift_en is high. dout is the word written
// DEPTH shifts earlier. All taps clear on reset.
module sdf_delay #(
    parameter int DEPTH = 8,
    parameter int W     = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        logic [W-1:0] q;
        if (i == 0) begin : g_head
            // Load the newest word into the first tap
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (shift_en) q <= din;
            end
        end else begin : g_body
            // Move the word one tap further along
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (shift_en) q <= g_tap[i-1].q;
            end
        end
    end

    assign dout = g_tap[DEPTH-1].q;

    // R3
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dout));

endmodule

// File: rtl/sdf_addsub.sv
// One component lane of the butterfly: two adders whose operands are
// chosen by the phase. The output adder passes the delayed word in the
// fill phase and forms head + x in the butterfly phase. The loop adder
// passes x in the fill phase and forms head + ~x (head - x - 1) in the
// butterfly phase. Assumes x is already sign-extended to W bits.
module sdf_addsub
    import sdf_pkg::*;
#(
    parameter int W = 11
) (
    input  phase_e       phase,
    input  logic [W-1:0] head,
    input  logic [W-1:0] x,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] fb_o
);

    logic [W-1:0] out_b;
    logic [W-1:0] loop_a;
    logic [W-1:0] loop_b;

    // Operand selection ahead of the adders
    always_comb begin
        out_b  = (phase == PH_BFLY) ? x    : '0;
        loop_a = (phase == PH_BFLY) ? head : '0;
        loop_b = (phase == PH_BFLY) ? ~x   : x;
    end

    assign sum_o = head + out_b;
    assign fb_o  = loop_a + loop_b;

endmodule

// File: rtl/sdf_bfly_stage.sv
// Radix-2 delay-feedback butterfly stage, one complex sample per valid
// cycle. Frames are 2*DEPTH samples: a fill half that stores the input
// and outputs the stored differences, then a butterfly half that outputs
// sums and stores differences. Output is registered and one bit wider
// than the input. Assumes DEPTH is a power of two.
module sdf_bfly_stage
    import sdf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IN_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_re,
    input  logic [IN_W-1:0] in_im,
    output logic            out_valid,
    output logic [IN_W:0]   out_re,
    output logic [IN_W:0]   out_im
);

    localparam int OUT_W   = IN_W + 1;
    localparam int LANES   = 2;
    localparam int STORE_W = LANES * OUT_W;

    phase_e             phase;
    logic               primed;
    logic [STORE_W-1:0] line_in;
    logic [STORE_W-1:0] line_out;
    logic [OUT_W-1:0]   x_ext  [LANES];
    logic [OUT_W-1:0]   head_l [LANES];
    logic [OUT_W-1:0]   sum_l  [LANES];
    logic [OUT_W-1:0]   fb_l   [LANES];

    sdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .phase    (phase),
        .primed   (primed)
    );

    sdf_delay #(.DEPTH(DEPTH), .W(STORE_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (line_in),
        .dout     (line_out)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IN_W-1:0] lane_in;
        logic [OUT_W:0]  gap;

        if (g == 0) begin : g_re
            assign lane_in = in_re;
        end else begin : g_im
            assign lane_in = in_im;
        end

        assign x_ext[g]  = {lane_in[IN_W-1], lane_in};
        assign head_l[g] = line_out[g*OUT_W +: OUT_W];
        assign line_in[g*OUT_W +: OUT_W] = fb_l[g];

        sdf_addsub #(.W(OUT_W)) u_addsub (
            .phase (phase),
            .head  (head_l[g]),
            .x     (x_ext[g]),
            .sum_o (sum_l[g]),
            .fb_o  (fb_l[g])
        );

        // Sum minus stored difference must equal 2*x + 1 in the butterfly phase
        assign gap = {sum_l[g][OUT_W-1], sum_l[g]} - {fb_l[g][OUT_W-1], fb_l[g]};

        // R4
        sumdiff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && phase == PH_BFLY) |-> gap == {x_ext[g], 1'b1});
    end

    // Register the result of each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid && primed;
            if (in_valid) begin
                out_re <= sum_l[0];
                out_im <= sum_l[1];
            end
        end
    end

    // R2
    out_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

endmodule

// File: tb/sdf_bfly_stage_tb.sv
// Bench for the delay-feedback butterfly stage. A behavioural model
// keeps the accepted sample history and is compared on every clock.
module sdf_bfly_stage_tb;

    localparam int D     = 8;
    localparam int IN_W  = 10;
    localparam int HIST  = 4096;
    localparam int MAXV  = (1 << (IN_W - 1)) - 1;
    localparam int MINV  = -(1 << (IN_W - 1));

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [IN_W-1:0] in_re;
    logic [IN_W-1:0] in_im;
    logic            out_valid;
    logic [IN_W:0]   out_re;
    logic [IN_W:0]   out_im;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    int xr [HIST];
    int xi [HIST];
    int prev_r = 0;
    int prev_i = 0;
    bit extreme = 1'b0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sdf_bfly_stage #(.DEPTH(D), .IN_W(IN_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (sample %0d)", tag, act, exp, n);
        end
    endtask

    // Hold reset for a few cycles, then check the cleared outputs (R1)
    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_re    = '0;
        in_im    = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk($signed(out_re) == 0, "R1 out_re", $signed(out_re), 0);
        chk($signed(out_im) == 0, "R1 out_im", $signed(out_im), 0);
        rst_n  = 1'b1;
        n      = 0;
        prev_r = 0;
        prev_i = 0;
    endtask

    // Drive one cycle from a negedge, then check the result at the next negedge
    task automatic step(input bit v, input int re, input int im);
        int er, ei, pos;
        string tag;
        in_valid = v;
        in_re    = IN_W'(re);
        in_im    = IN_W'(im);
        @(posedge clk);
        @(negedge clk);
        if (!v) begin
            chk(out_valid == 1'b0, "R3 valid on idle", int'(out_valid), 0);
            chk($signed(out_re) == prev_r, "R3 re held", $signed(out_re), prev_r);
            chk($signed(out_im) == prev_i, "R3 im held", $signed(out_im), prev_i);
        end else begin
            xr[n] = re;
            xi[n] = im;
            chk(out_valid == (n >= D), "R2,R8 out_valid", int'(out_valid), int'(n >= D));
            if (n >= D) begin
                pos = n % (2 * D);
                if (pos >= D) begin
                    er  = xr[n-D] + xr[n];
                    ei  = xi[n-D] + xi[n];
                    tag = extreme ? "R6,R4" : "R4,R7 sum";
                end else begin
                    er  = xr[n-2*D] - xr[n-D] - 1;
                    ei  = xi[n-2*D] - xi[n-D] - 1;
                    tag = extreme ? "R6,R5" : "R5,R7 diff";
                end
                chk($signed(out_re) == er, {tag, " re"}, $signed(out_re), er);
                chk($signed(out_im) == ei, {tag, " im"}, $signed(out_im), ei);
            end
            n++;
        end
        prev_r = $signed(out_re);
        prev_i = $signed(out_im);
    endtask

    function automatic int rnd();
        return int'($urandom_range(2 * MAXV + 1)) + MINV;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Ramp without gaps: pairing distance and frame length (R4, R5, R7)
        for (int k = 0; k < 6 * D; k++) step(1'b1, k - 3 * D, 2 * D - k);

        // Random data with random idle cycles (R3, R4, R5)
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(9) < 3) step(1'b0, rnd(), rnd());
            else                       step(1'b1, rnd(), rnd());
        end

        // Full-scale operands (R6)
        do_reset();
        extreme = 1'b1;
        for (int k = 0; k < 2 * D; k++) step(1'b1, MAXV, MINV);
        for (int k = 0; k < 2 * D; k++) step(1'b1, MINV, MAXV);
        for (int k = 0; k < 2 * D; k++) step(1'b1, (k < D) ? MAXV : MINV, (k < D) ? MINV : MAXV);
        for (int k = 0; k < 2 * D; k++) step(1'b1, (k < D) ? MINV : MAXV, (k < D) ? MAXV : MINV);
        for (int k = 0; k < 2 * D; k++) step(1'b1, MAXV, MAXV);
        for (int k = 0; k < 2 * D; k++) step(1'b1, MINV, MINV);
        extreme = 1'b0;

        // Reset in mid-frame, then frame position and priming restart (R1, R2)
        for (int k = 0; k < D / 2 + 1; k++) step(1'b1, rnd(), rnd());
        do_reset();
        for (int k = 0; k < 4 * D; k++) step(1'b1, rnd(), rnd());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule